// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-Mode Tracker

This block follows the power state of an SDRAM device as seen from the controller side. On every clock edge it combines the clock-enable level sampled at that edge with the level sampled at the previous edge, the decoded command, a flag saying that every bank is idle, and a flag saying that a read or write burst is running. From these inputs it decides whether the device stays in normal operation or moves into power-down, self refresh or clock suspend. It also decides when the device leaves that mode again.

Each low-power mode ends in its own way. Clock suspend ends on the first rising clock-enable, whatever command is present. Power-down needs an idle command on the exit edge and returns to normal at once. Self refresh needs an idle command on the exit edge and then passes through a recovery window of `T_XSR` edges. During that window only idle commands are allowed, and at least two of them must be seen. A command-accept output tells the controller when a real command may be issued. A one-cycle illegal flag reports any combination that the rules do not allow. When the flag is raised the mode is left unchanged.

States, with their `mode_o` codes: NORMAL (0), PWRDN (1), SELFREF (2), SUSPEND (3), RECOVER (4). Transitions: NORMAL to SUSPEND, PWRDN or SELFREF on a falling clock-enable. PWRDN to NORMAL, SELFREF to RECOVER and SUSPEND to NORMAL on a rising clock-enable. RECOVER to NORMAL when its window closes. Every other case is a self-loop, and an illegal case is a self-loop that also raises the flag.

Top module: `pmt_power_mode`

## Requirements
- R1: During reset, and after it until the first clock edge, `mode_o` is 0 (NORMAL), `accept_o` is 1 and `illegal_o` is 0.
- R2: When clock-enable was low at the previous edge and is low at this edge, PWRDN, SELFREF and SUSPEND are held unchanged for any command, with no illegal flag.
- R3: From NORMAL, a falling clock-enable with `rw_active_i`=0, `banks_idle_i`=1 and an idle command enters PWRDN on that edge. An idle command is `cmd_i` 0 (inhibit) or 1 (no-op).
- R4: From NORMAL, a falling clock-enable with `rw_active_i`=0, `banks_idle_i`=1 and `cmd_i`=6 (refresh) enters SELFREF.
- R5: From NORMAL, a falling clock-enable with `rw_active_i`=1 enters SUSPEND for any command and any value of `banks_idle_i`. This rule has priority over R3 and R4.
- R6: A rising clock-enable in PWRDN or SELFREF with an idle command goes from PWRDN to NORMAL or from SELFREF to RECOVER. With any other command on that edge, the edge is illegal.
- R7: A rising clock-enable in SUSPEND returns to NORMAL for any command. The command on that exit edge is not accepted, because `accept_o` is still low while that edge is sampled.
- R8: RECOVER is entered only from SELFREF. It returns to NORMAL on the first edge k after the exit edge for which all three conditions hold: at least `T_XSR` edges have passed since the exit edge, at least two of those edges carried an idle command, and edge k itself is legal.
- R9: `accept_o` is 1 in NORMAL and 0 in every other state, including RECOVER.
- R10: `illegal_o` is high for exactly the one cycle after an edge that breaks the rules, and `mode_o` keeps its value across that edge. The illegal edges are:
  - In NORMAL: a falling clock-enable that matches none of R3 to R5, or a low previous clock-enable.
  - In PWRDN, SELFREF or SUSPEND: a high current clock-enable other than a legal exit.
  - In RECOVER: a low clock-enable or a non-idle command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock-enable level sampled at this edge |
| cmd_i | input | 3 | Decoded command: 0 inhibit, 1 no-op, 2 activate, 3 read, 4 write, 5 precharge, 6 refresh, 7 load mode |
| banks_idle_i | input | 1 | All banks precharged and idle |
| rw_active_i | input | 1 | A read or write burst is in progress |
| mode_o | output | 3 | Current power state code |
| accept_o | output | 1 | A non-idle command may be issued |
| illegal_o | output | 1 | The previous edge broke the transition rules |

## Verification
The hardest situation to reach is the end of the recovery window when that end is delayed. Only a self-refresh exit leads there. The window must then contain a rejected command, or a clock-enable glitch, or too few idle commands. In each of those cases the return to NORMAL moves to a later edge than `T_XSR`. The stimulus first drives a directed self-refresh entry, hold and exit, and places a non-idle command inside the window. It then runs constrained-random cycles in which refresh commands are common and clock-enable changes seldom. This lets self-refresh entries happen often and lets the window run long enough to be disturbed in varied ways.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    typedef enum logic [2:0] {
        CMD_INHIBIT   = 3'd0,
        CMD_NOP       = 3'd1,
        CMD_ACTIVATE  = 3'd2,
        CMD_READ      = 3'd3,
        CMD_WRITE     = 3'd4,
        CMD_PRECHARGE = 3'd5,
        CMD_REFRESH   = 3'd6,
        CMD_LOAD_MODE = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        PM_NORMAL  = 3'd0,
        PM_PWRDN   = 3'd1,
        PM_SELFREF = 3'd2,
        PM_SUSPEND = 3'd3,
        PM_RECOVER = 3'd4
    } pm_e;

    // {previous, current} clock-enable sample
    typedef enum logic [1:0] {
        CK_LL = 2'b00,
        CK_LH = 2'b01,
        CK_HL = 2'b10,
        CK_HH = 2'b11
    } cke_pair_e;

    function automatic logic is_idle_cmd(cmd_e c);
        return (c == CMD_INHIBIT) || (c == CMD_NOP);
    endfunction

endpackage

// File: rtl/pmt_cke_edge.sv
module pmt_cke_edge
    import pmt_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      cke_i,
    output cke_pair_e pair_o
);
    logic cke_q;

    // Clock enable is taken as high out of reset
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cke_q <= 1'b1;
        else         cke_q <= cke_i;
    end

    assign pair_o = cke_pair_e'({cke_q, cke_i});
endmodule

// File: rtl/pmt_xsr_timer.sv
module pmt_xsr_timer #(
    parameter int unsigned T_XSR    = 8,
    parameter int unsigned MIN_IDLE = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic run_i,
    input  logic idle_i,
    output logic expire_o
);
    localparam int unsigned CW = $clog2(T_XSR + 1);
    localparam int unsigned NW = $clog2(MIN_IDLE + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(T_XSR);
    localparam logic [NW-1:0] IDLE_MAX = NW'(MIN_IDLE);

    logic [CW-1:0] cnt_q, cnt_inc;
    logic [NW-1:0] idle_q, idle_inc;

    // Both counters saturate, so a long window cannot wrap
    always_comb begin
        cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        idle_inc = (idle_i && (idle_q != IDLE_MAX)) ? idle_q + 1'b1 : idle_q;
        expire_o = run_i && (cnt_inc == CNT_MAX) && (idle_inc == IDLE_MAX);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            idle_q <= '0;
        end else if (start_i) begin
            cnt_q  <= '0;
            idle_q <= '0;
        end else if (run_i) begin
            cnt_q  <= cnt_inc;
            idle_q <= idle_inc;
        end
    end
endmodule

// File: rtl/pmt_power_mode.sv
module pmt_power_mode
    import pmt_pkg::*;
#(
    parameter int unsigned T_XSR = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       cke_i,
    input  logic [2:0] cmd_i,
    input  logic       banks_idle_i,
    input  logic       rw_active_i,
    output logic [2:0] mode_o,
    output logic       accept_o,
    output logic       illegal_o
);
    localparam int unsigned MIN_IDLE = 2;

    cmd_e      cmd;
    cke_pair_e pair;
    pm_e       state_q, state_d;
    logic      illegal_q, bad;
    logic      idle, xsr_start, xsr_run, xsr_expire;

    assign cmd  = cmd_e'(cmd_i);
    assign idle = is_idle_cmd(cmd);

    pmt_cke_edge u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cke_i  (cke_i),
        .pair_o (pair)
    );

    assign xsr_run = (state_q == PM_RECOVER);

    pmt_xsr_timer #(
        .T_XSR    (T_XSR),
        .MIN_IDLE (MIN_IDLE)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (xsr_start),
        .run_i    (xsr_run),
        .idle_i   (idle),
        .expire_o (xsr_expire)
    );

    // Next-state decision
    always_comb begin
        state_d   = state_q;
        bad       = 1'b0;
        xsr_start = 1'b0;
        unique case (state_q)
            PM_NORMAL: begin
                case (pair)
                    CK_HH: ;
                    CK_HL: begin
                        if (rw_active_i)                               state_d = PM_SUSPEND;
                        else if (banks_idle_i && idle)                 state_d = PM_PWRDN;
                        else if (banks_idle_i && cmd == CMD_REFRESH)   state_d = PM_SELFREF;
                        else                                           bad     = 1'b1;
                    end
                    default: bad = 1'b1;
                endcase
            end
            PM_PWRDN, PM_SELFREF: begin
                case (pair)
                    CK_LL: ;
                    CK_LH: begin
                        if (idle) begin
                            state_d   = (state_q == PM_PWRDN) ? PM_NORMAL : PM_RECOVER;
                            xsr_start = (state_q == PM_SELFREF);
                        end else begin
                            bad = 1'b1;
                        end
                    end
                    default: bad = 1'b1;
                endcase
            end
            PM_SUSPEND: begin
                case (pair)
                    CK_LL: ;
                    CK_LH:   state_d = PM_NORMAL;
                    default: bad     = 1'b1;
                endcase
            end
            PM_RECOVER: begin
                bad = !cke_i || !idle;
                if (!bad && xsr_expire) state_d = PM_NORMAL;
            end
            default: begin
                state_d = PM_NORMAL;
                bad     = 1'b1;
            end
        endcase
        if (bad) state_d = state_q;
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q   <= PM_NORMAL;
            illegal_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            illegal_q <= bad;
        end
    end

    // Outputs
    always_comb begin
        mode_o    = state_q;
        accept_o  = (state_q == PM_NORMAL);
        illegal_o = illegal_q;
    end
endmodule

// File: rtl/pmt_power_mode_chk.sv
module pmt_power_mode_chk
    import pmt_pkg::*;
(
    input logic       clk_i,
    input logic       rst_ni,
    input logic       cke_i,
    input logic [2:0] cmd_i,
    input logic       banks_idle_i,
    input logic       rw_active_i,
    input logic [2:0] mode_o,
    input logic       accept_o,
    input logic       illegal_o
);
    logic prev_cke;
    logic low_pwr;
    logic idle_c;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_cke <= 1'b1;
        else         prev_cke <= cke_i;
    end

    assign low_pwr = (mode_o == PM_PWRDN) || (mode_o == PM_SELFREF) || (mode_o == PM_SUSPEND);
    assign idle_c  = (cmd_i == CMD_NOP) || (cmd_i == CMD_INHIBIT);

    p_lowpower_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!prev_cke && !cke_i && low_pwr) |=> (mode_o == $past(mode_o)) && !illegal_o);

    p_pwrdn_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (prev_cke && !cke_i && mode_o == PM_NORMAL && !rw_active_i && banks_idle_i && idle_c)
        |=> mode_o == PM_PWRDN);

    p_sref_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (prev_cke && !cke_i && mode_o == PM_NORMAL && !rw_active_i && banks_idle_i
         && cmd_i == CMD_REFRESH) |=> mode_o == PM_SELFREF);

    p_suspend_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (prev_cke && !cke_i && mode_o == PM_NORMAL && rw_active_i) |=> mode_o == PM_SUSPEND);

    p_bad_exit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!prev_cke && cke_i && (mode_o == PM_PWRDN || mode_o == PM_SELFREF) && !idle_c)
        |=> illegal_o && (mode_o == $past(mode_o)));

    p_suspend_exit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!prev_cke && cke_i && mode_o == PM_SUSPEND) |=> mode_o == PM_NORMAL);

    p_recover_from_sref_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == PM_RECOVER && $past(mode_o) != PM_RECOVER) |-> $past(mode_o) == PM_SELFREF);

    p_accept_normal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_o |-> mode_o == PM_NORMAL);

    p_illegal_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> mode_o == $past(mode_o));
endmodule

bind pmt_power_mode pmt_power_mode_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cke_i        (cke_i),
    .cmd_i        (cmd_i),
    .banks_idle_i (banks_idle_i),
    .rw_active_i  (rw_active_i),
    .mode_o       (mode_o),
    .accept_o     (accept_o),
    .illegal_o    (illegal_o)
);

// File: tb/pmt_power_mode_tb.sv
module pmt_power_mode_tb;
    localparam int TB_XSR = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic [2:0] cmd = 3'd1;
    logic       banks_idle = 1'b1;
    logic       rw_active = 1'b0;
    logic [2:0] mode;
    logic       accept;
    logic       illegal;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    int    m_mode = 0;
    bit    m_prev = 1;
    int    m_cnt = 0;
    int    m_nops = 0;
    bit    m_ill = 0;
    string m_tag = "R1";

    always #4 clk = ~clk;

    pmt_power_mode #(.T_XSR(TB_XSR)) u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cke_i        (cke),
        .cmd_i        (cmd),
        .banks_idle_i (banks_idle),
        .rw_active_i  (rw_active),
        .mode_o       (mode),
        .accept_o     (accept),
        .illegal_o    (illegal)
    );

    function automatic bit idle_c(logic [2:0] c);
        return (c == 3'd0) || (c == 3'd1);
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // expected result of one edge, computed from the requirements
    task automatic model_step();
        bit    bad = 0;
        int    nm  = m_mode;
        string tg  = "R9";
        int    ncnt = (m_cnt + 1 > TB_XSR) ? TB_XSR : m_cnt + 1;
        int    nn   = (m_nops + int'(idle_c(cmd)) > 2) ? 2 : m_nops + int'(idle_c(cmd));
        case (m_mode)
            0: begin
                if (m_prev && cke) tg = "R9";
                else if (m_prev && !cke) begin
                    if (rw_active)                           begin nm = 3; tg = "R5"; end
                    else if (banks_idle && idle_c(cmd))      begin nm = 1; tg = "R3"; end
                    else if (banks_idle && cmd == 3'd6)      begin nm = 2; tg = "R4"; end
                    else                                     begin bad = 1; tg = "R10"; end
                end else begin bad = 1; tg = "R10"; end
            end
            1, 2: begin
                if (!m_prev && !cke) tg = "R2";
                else if (!m_prev && cke && idle_c(cmd)) begin nm = (m_mode == 1) ? 0 : 4; tg = "R6"; end
                else begin bad = 1; tg = (!m_prev && cke) ? "R6" : "R10"; end
            end
            3: begin
                if (!m_prev && !cke)     tg = "R2";
                else if (!m_prev && cke) begin nm = 0; tg = "R7"; end
                else                     begin bad = 1; tg = "R10"; end
            end
            default: begin
                bad = !cke || !idle_c(cmd);
                tg  = bad ? "R10" : "R8";
                if (!bad && ncnt >= TB_XSR && nn >= 2) nm = 0;
            end
        endcase
        if (m_mode == 2 && nm == 4) begin m_cnt = 0; m_nops = 0; end
        else if (m_mode == 4)       begin m_cnt = ncnt; m_nops = nn; end
        m_prev = cke;
        m_mode = nm;
        m_ill  = bad;
        m_tag  = tg;
    endtask

    task automatic check_outputs();
        check(m_tag, "mode", int'(mode), m_mode);
        check("R9", "accept", int'(accept), int'(m_mode == 0));
        check(m_tag, "illegal", int'(illegal), int'(m_ill));
    endtask

    // called at a falling edge: drive, advance model, check at next falling edge
    task automatic tick(logic [2:0] c, logic ck, logic bi, logic rw);
        cmd = c; cke = ck; banks_idle = bi; rw_active = rw;
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_outputs();
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "mode in reset", int'(mode), 0);
        check("R1", "accept in reset", int'(accept), 1);
        rst_n = 1'b1;
        #1;
        check("R1", "illegal after reset", int'(illegal), 0);

        // normal traffic, R9
        tick(3'd2, 1, 0, 0);
        tick(3'd3, 1, 0, 1);
        // power-down entry, hold, bad exit, recovery, exit: R3 R2 R6 R10
        tick(3'd1, 0, 1, 0);
        tick(3'd3, 0, 1, 0);
        tick(3'd2, 1, 1, 0);
        tick(3'd1, 1, 1, 0);
        tick(3'd1, 0, 1, 0);
        tick(3'd0, 1, 1, 0);
        tick(3'd1, 1, 1, 0);
        // self refresh entry, hold, exit into recovery window with a rejected command: R4 R8
        tick(3'd6, 0, 1, 0);
        tick(3'd7, 0, 1, 0);
        tick(3'd1, 1, 1, 0);
        tick(3'd2, 1, 1, 0);
        for (int i = 0; i < TB_XSR + 2; i++) tick(3'd1, 1, 1, 0);
        // recovery window with too few idle commands early on
        tick(3'd6, 0, 1, 0);
        tick(3'd0, 1, 1, 0);
        for (int i = 0; i < TB_XSR - 1; i++) tick(3'd5, 1, 1, 0);
        for (int i = 0; i < 4; i++) tick(3'd0, 1, 1, 0);
        // suspend entry takes priority over refresh, exit with a read: R5 R7
        tick(3'd6, 0, 1, 1);
        tick(3'd4, 0, 0, 1);
        tick(3'd3, 1, 0, 1);
        tick(3'd4, 0, 0, 1);
        tick(3'd1, 1, 0, 0);
        // illegal entries in normal: R10
        tick(3'd1, 0, 0, 0);
        tick(3'd1, 0, 0, 0);
        tick(3'd1, 1, 0, 0);
        tick(3'd2, 0, 1, 0);
        tick(3'd1, 1, 1, 0);

        // constrained random
        void'($urandom(32'd20240601));
        for (int i = 0; i < 5000; i++) begin
            logic       nck = cke;
            logic [2:0] nc;
            int         r = int'($urandom_range(0, 99));
            if ($urandom_range(0, 3) == 0) nck = ~cke;
            if (r < 45)      nc = 3'(r % 2);
            else if (r < 65) nc = 3'd6;
            else             nc = 3'($urandom_range(0, 7));
            tick(nc, nck, ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) == 0));
        end
        summary();
    end
endmodule